// File: doc/BRIEF.md
# Static memory strobe timing controller

This block runs single accesses to external asynchronous memories such as SRAM or parallel flash, across six chip selects. Each chip select owns a bank of timing words. The words set, in clock cycles, when the chip-select strobe and the read or write strobe go low after the address appears, how long each stays low, and how long the whole access lasts. A mode word per bank picks the edge on which read data is taken, the point from which write data is driven, how byte lanes are signalled, and the data bus width.

A host presents one request at a time: a chip-select index, address, direction, write data and byte enables. When the request is accepted, the controller copies that bank's timings and counts through the access. It holds the address steady, moves the active-low strobes, the byte-lane lines and the data output enable, and returns the captured read data with a one-cycle response pulse. The timing words are written through a small word-wide register port with combinational read-back.

Top module: `smc_strobe_ctrl`

## Requirements
- R1: Bank n sits at byte offset 16*n. Its words are: +0 setup, +4 pulse, +8 cycle, +12 mode. Setup holds 6-bit fields and pulse holds 7-bit fields, both at bits 0 (write strobe), 8 (chip select during writes), 16 (read strobe) and 24 (chip select during reads). Cycle holds a 9-bit write length at bit 0 and a 9-bit read length at bit 16. Mode holds the read sample select at bit 0, the write drive select at bit 1, byte-write signalling at bit 8 and the width code at bits 13:12. Read-back returns the stored word with every unimplemented bit at zero.
- R2: `req_ready` is high exactly when no access runs. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The access then lasts max(C,1) cycles, counted t = 0 from the cycle after acceptance, where C is the cycle length for its direction. `resp_valid` is high for the single cycle after the last one, and a new request can be taken in that same cycle.
- R3: A strobe with setup S and pulse P is low in access cycle t exactly when S <= t < S+P and t < max(C,1). A pulse of zero keeps it high for the whole access.
- R4: A read moves the chip select with the read-side chip-select fields and `mem_nrd_n` with the read-strobe fields. A write moves the chip select with the write-side chip-select fields and the write strobe with the write-strobe fields. `mem_nrd_n` never goes low on a write.
- R5: `mem_addr` holds the accepted address for the whole access. Only the selected chip-select line may go low.
- R6: With mode bit 0 clear, read data is taken from `mem_din` at the clock edge that ends the chip select's last low cycle. With the bit set, the read strobe's last low cycle is used instead. If that strobe never goes low, the data is taken at the edge ending the access's last cycle.
- R7: On a write, `mem_oe` is high from access cycle S to the end of the access. S is the write-side chip-select setup when mode bit 1 is clear, and the write-strobe setup when it is set. While `mem_oe` is high, `mem_dout` carries the accepted write data. `mem_oe` is low for reads and when idle.
- R8: With mode bit 8 clear, `mem_nwe_n` follows the write strobe. `mem_nbs_n` is low, for the whole access, on each lane enabled by both the width and `req_be` for writes, and on every lane of the width for reads.
- R9: With mode bit 8 set, `mem_nwe_n` stays high. Each lane's `mem_nbs_n` bit acts as that lane's write strobe: it is low when the write strobe is low and the lane is enabled by both the width and `req_be`. All `mem_nbs_n` bits stay high on reads.
- R10: Width code 0 uses lane 0 only, code 1 uses lanes 0 and 1, and codes 2 and 3 use all four lanes. Read data bits on lanes outside the width are returned as zero.
- R11: An access uses the timings stored at the clock edge that accepts it. A register write in that same cycle, or during the access, affects only later accesses.
- R12: Register writes to a bank index of NUM_CS or above, or to an offset that is not word aligned, are ignored, and such banks read back as zero. A request to such a chip select runs as a one-cycle access with every strobe high and width code 0.
- R13: While reset is asserted, and after it is released: the block is idle, every strobe and lane line is high, `mem_oe` and `resp_valid` are low, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CSW+4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read-back at `cfg_addr` |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cs | input | CSW | Chip-select index |
| req_addr | input | AW | Access address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| resp_valid | output | 1 | Access finished pulse |
| resp_rdata | output | 32 | Captured read data |
| mem_addr | output | AW | Memory address |
| mem_ncs_n | output | NUM_CS | Active-low chip selects |
| mem_nrd_n | output | 1 | Active-low read strobe |
| mem_nwe_n | output | 1 | Active-low write strobe |
| mem_nbs_n | output | 4 | Active-low byte selects or lane write strobes |
| mem_dout | output | 32 | Write data toward memory |
| mem_oe | output | 1 | Data bus output enable |
| mem_din | input | 32 | Read data from memory |

## Verification
Two things can land on the same clock edge here: a timing register write, and the edge that accepts a request. The write can also land on an edge in the middle of an access. The bench raises `cfg_we` in the request cycle, and again in the first access cycle, with a different setup word. It then checks every strobe cycle against the old timings, and checks the next access against the new ones. The read capture edge can also coincide with the end of the access when the strobe window runs past the cycle length. This happens in the sweeps, which use zero and short cycle lengths and are judged by the bench's own capture-cycle arithmetic on a `mem_din` pattern that changes every cycle.

// File: rtl/smc_strobe_ctrl.sv
module smc_strobe_ctrl #(
  parameter int NUM_CS = 6,
  parameter int AW = 24,
  parameter int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  parameter int CFG_AW = CSW + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              resp_valid,
  output logic [31:0]       resp_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic [NUM_CS-1:0] mem_ncs_n,
  output logic              mem_nrd_n,
  output logic              mem_nwe_n,
  output logic [3:0]        mem_nbs_n,
  output logic [31:0]       mem_dout,
  output logic              mem_oe,
  input  logic [31:0]       mem_din
);
  localparam int NB = 4;
  localparam logic [31:0] M_SETUP = 32'h3F3F3F3F;
  localparam logic [31:0] M_PULSE = 32'h7F7F7F7F;
  localparam logic [31:0] M_CYCLE = 32'h01FF01FF;
  localparam logic [31:0] M_MODE  = 32'h00003103;

  logic [31:0] r_setup [NUM_CS];
  logic [31:0] r_pulse [NUM_CS];
  logic [31:0] r_cycle [NUM_CS];
  logic [31:0] r_mode  [NUM_CS];

  wire [CSW-1:0] cfg_idx = cfg_addr[CFG_AW-1:4];
  wire [1:0]     cfg_sel = cfg_addr[3:2];
  wire           cfg_hit = (32'(cfg_idx) < NUM_CS) && (cfg_addr[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) begin
        r_setup[i] <= '0;
        r_pulse[i] <= '0;
        r_cycle[i] <= '0;
        r_mode[i]  <= '0;
      end
    end else if (cfg_we && cfg_hit) begin
      case (cfg_sel)
        2'd0: r_setup[cfg_idx] <= cfg_wdata & M_SETUP;
        2'd1: r_pulse[cfg_idx] <= cfg_wdata & M_PULSE;
        2'd2: r_cycle[cfg_idx] <= cfg_wdata & M_CYCLE;
        default: r_mode[cfg_idx] <= cfg_wdata & M_MODE;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_hit) begin
      case (cfg_sel)
        2'd0: cfg_rdata = r_setup[cfg_idx];
        2'd1: cfg_rdata = r_pulse[cfg_idx];
        2'd2: cfg_rdata = r_cycle[cfg_idx];
        default: cfg_rdata = r_mode[cfg_idx];
      endcase
    end
  end

  logic           busy, wr, rmode, wmode, bw;
  logic [CSW-1:0] csi;
  logic [8:0]     t;
  logic [9:0]     ceff;
  logic [5:0]     cs_s, st_s;
  logic [6:0]     cs_p, st_p;
  logic [1:0]     dbw;
  logic [AW-1:0]  addr_q;
  logic [31:0]    wdata_q, rdata_q;
  logic [3:0]     be_q;

  function automatic logic on_f(input logic [9:0] k, input logic [5:0] s,
                                input logic [6:0] p, input logic [9:0] c);
    return (k >= {4'b0, s}) && (k < ({4'b0, s} + {3'b0, p})) && (k < c);
  endfunction

  wire       req_hit = 32'(req_cs) < NUM_CS;
  wire       accept  = req_valid && !busy;
  wire [9:0] tk      = {1'b0, t};
  wire [9:0] tk1     = tk + 10'd1;
  wire       last    = busy && (tk == ceff - 10'd1);
  wire       cs_on   = busy && on_f(tk, cs_s, cs_p, ceff);
  wire       st_on   = busy && on_f(tk, st_s, st_p, ceff);
  wire       cs_nx   = on_f(tk1, cs_s, cs_p, ceff);
  wire       st_nx   = on_f(tk1, st_s, st_p, ceff);
  wire [5:0] cap_s   = rmode ? st_s : cs_s;
  wire [6:0] cap_p   = rmode ? st_p : cs_p;
  wire       cap_on  = rmode ? st_on : cs_on;
  wire       cap_nx  = rmode ? st_nx : cs_nx;
  wire       never   = (cap_p == 7'd0) || ({4'b0, cap_s} >= ceff);
  wire       cap_now = busy && !wr && ((cap_on && !cap_nx) || (last && never));

  wire [3:0]  lm      = (dbw == 2'd0) ? 4'b0001 : (dbw == 2'd1) ? 4'b0011 : 4'b1111;
  wire [31:0] dmask   = {{8{lm[3]}}, {8{lm[2]}}, {8{lm[1]}}, {8{lm[0]}}};
  wire [3:0]  be_eff  = be_q & lm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; wr <= 1'b0; csi <= '0; t <= '0; ceff <= 10'd1;
      cs_s <= '0; cs_p <= '0; st_s <= '0; st_p <= '0;
      rmode <= 1'b0; wmode <= 1'b0; bw <= 1'b0; dbw <= '0;
      addr_q <= '0; wdata_q <= '0; be_q <= '0; rdata_q <= '0;
      resp_valid <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      if (cap_now) rdata_q <= mem_din & dmask;
      if (accept) begin
        busy <= 1'b1; wr <= req_write; csi <= req_cs; t <= '0;
        addr_q <= req_addr; wdata_q <= req_wdata; be_q <= req_be;
        if (req_hit) begin
          cs_s <= req_write ? r_setup[req_cs][13:8] : r_setup[req_cs][29:24];
          st_s <= req_write ? r_setup[req_cs][5:0]  : r_setup[req_cs][21:16];
          cs_p <= req_write ? r_pulse[req_cs][14:8] : r_pulse[req_cs][30:24];
          st_p <= req_write ? r_pulse[req_cs][6:0]  : r_pulse[req_cs][22:16];
          ceff <= (req_write ? r_cycle[req_cs][8:0] : r_cycle[req_cs][24:16]) == 9'd0 ? 10'd1
                : {1'b0, req_write ? r_cycle[req_cs][8:0] : r_cycle[req_cs][24:16]};
          rmode <= r_mode[req_cs][0];
          wmode <= r_mode[req_cs][1];
          bw    <= r_mode[req_cs][8];
          dbw   <= r_mode[req_cs][13:12];
        end else begin
          cs_s <= '0; st_s <= '0; cs_p <= '0; st_p <= '0; ceff <= 10'd1;
          rmode <= 1'b0; wmode <= 1'b0; bw <= 1'b0; dbw <= '0;
        end
      end else if (last) begin
        busy <= 1'b0;
        resp_valid <= 1'b1;
      end else if (busy) begin
        t <= t + 9'd1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CS; g++) begin : g_ncs
      assign mem_ncs_n[g] = !(cs_on && (32'(csi) == g));
    end
  endgenerate

  assign req_ready  = !busy;
  assign resp_rdata = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_dout   = wdata_q;
  assign mem_nrd_n  = !(st_on && !wr);
  assign mem_nwe_n  = !(st_on && wr && !bw);
  assign mem_oe     = busy && wr && (tk >= {4'b0, wmode ? st_s : cs_s});
  assign mem_nbs_n  = !busy ? {NB{1'b1}}
                    : bw    ? ~(be_eff & {NB{st_on && wr}})
                    : wr    ? ~be_eff : ~lm;
endmodule

// File: rtl/smc_strobe_ctrl_chk.sv
module smc_strobe_ctrl_chk #(
  parameter int NUM_CS = 6,
  parameter int AW = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              resp_valid,
  input logic [AW-1:0]     mem_addr,
  input logic [NUM_CS-1:0] mem_ncs_n,
  input logic              mem_nrd_n,
  input logic              mem_nwe_n,
  input logic [3:0]        mem_nbs_n,
  input logic              mem_oe
);
  // R5
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ncs_n));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((&mem_ncs_n) && mem_nrd_n && mem_nwe_n && (&mem_nbs_n) && !mem_oe));

  // R7
  oe_vs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_oe && !mem_nrd_n));

  // R2
  resp_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(!req_ready));

  // R2
  resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
endmodule

bind smc_strobe_ctrl smc_strobe_ctrl_chk #(.NUM_CS(NUM_CS), .AW(AW)) u_chk (.*);

// File: tb/tb_smc_strobe_ctrl.sv
`timescale 1ns/1ps
module tb_smc_strobe_ctrl;
  localparam int NUM_CS = 6;
  localparam int AW = 24;
  localparam int CSW = 3;
  localparam int CFG_AW = CSW + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CFG_AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [CSW-1:0] req_cs = '0;
  logic [AW-1:0] req_addr = '0, mem_addr;
  logic [31:0] req_wdata = '0, resp_rdata, mem_dout, mem_din = '0;
  logic [3:0] req_be = '0, mem_nbs_n;
  logic resp_valid, mem_nrd_n, mem_nwe_n, mem_oe;
  logic [NUM_CS-1:0] mem_ncs_n;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  logic [31:0] m_setup [8], m_pulse [8], m_cycle [8], m_mode [8];

  always #5 clk = ~clk;

  smc_strobe_ctrl #(.NUM_CS(NUM_CS), .AW(AW)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(input int sel);
    case (sel)
      0: return 32'h3F3F3F3F;
      1: return 32'h7F7F7F7F;
      2: return 32'h01FF01FF;
      default: return 32'h00003103;
    endcase
  endfunction

  function automatic void model_wr(input int idx, input int sel, input logic [31:0] d);
    if (idx < NUM_CS) begin
      case (sel)
        0: m_setup[idx] = d & wmask(0);
        1: m_pulse[idx] = d & wmask(1);
        2: m_cycle[idx] = d & wmask(2);
        default: m_mode[idx] = d & wmask(3);
      endcase
    end
  endfunction

  task automatic cfg_wr(input int idx, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = CFG_AW'(idx * 16 + sel * 4); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_wr(idx, sel, d);
  endtask

  task automatic set_cs(input int cs, input logic [31:0] s, input logic [31:0] p,
                        input logic [31:0] c, input logic [31:0] m);
    cfg_wr(cs, 0, s); cfg_wr(cs, 1, p); cfg_wr(cs, 2, c); cfg_wr(cs, 3, m);
  endtask

  function automatic logic [31:0] pat(input int k);
    return {8'h5A ^ 8'(k), 8'(k * 7 + 1), ~8'(k), 8'(k * 13 + 5)};
  endfunction

  function automatic bit on_b(input int k, input int s, input int p, input int c);
    return (k >= s) && (k < s + p) && (k < c);
  endfunction

  // cfgwhen: 0 none, 1 setup write in the accept cycle, 2 setup write in access cycle 0
  task automatic run_acc(input int cs, input bit wr, input logic [AW-1:0] addr,
                         input logic [31:0] wd, input logic [3:0] be,
                         input int cfgwhen, input logic [31:0] newsetup);
    logic [31:0] su, pu, cy, mo;
    int cs_s, cs_p, st_s, st_p, c, ceff, lm, s_c, p_c, cap;
    bit rm, wm, bwm;
    logic [31:0] dm, exp_rd;
    su = (cs < NUM_CS) ? m_setup[cs] : 32'h0;
    pu = (cs < NUM_CS) ? m_pulse[cs] : 32'h0;
    cy = (cs < NUM_CS) ? m_cycle[cs] : 32'h0;
    mo = (cs < NUM_CS) ? m_mode[cs]  : 32'h0;
    cs_s = wr ? int'(su[13:8]) : int'(su[29:24]);
    st_s = wr ? int'(su[5:0])  : int'(su[21:16]);
    cs_p = wr ? int'(pu[14:8]) : int'(pu[30:24]);
    st_p = wr ? int'(pu[6:0])  : int'(pu[22:16]);
    c    = wr ? int'(cy[8:0])  : int'(cy[24:16]);
    ceff = (c == 0) ? 1 : c;
    rm = mo[0]; wm = mo[1]; bwm = mo[8];
    lm = (mo[13:12] == 2'd0) ? 1 : (mo[13:12] == 2'd1) ? 3 : 15;
    dm = {{8{lm[3]}}, {8{lm[2]}}, {8{lm[1]}}, {8{lm[0]}}};
    s_c = rm ? st_s : cs_s;
    p_c = rm ? st_p : cs_p;
    if (p_c == 0 || s_c >= ceff) cap = ceff - 1;
    else cap = ((s_c + p_c < ceff) ? s_c + p_c : ceff) - 1;
    exp_rd = pat(cap) & dm;

    @(negedge clk);
    chk("R2 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_cs = CSW'(cs); req_addr = addr;
    req_wdata = wd; req_be = be;
    if (cfgwhen == 1) begin
      cfg_we = 1'b1; cfg_addr = CFG_AW'(cs * 16); cfg_wdata = newsetup;
      model_wr(cs, 0, newsetup);
    end
    for (int k = 0; k < ceff; k++) begin
      logic [31:0] e_ncs, e_nbs;
      bit cs_on, st_on, e_oe;
      @(negedge clk);
      req_valid = 1'b0;
      if (cfgwhen == 1 || (cfgwhen == 2 && k == 1)) cfg_we = 1'b0;
      if (cfgwhen == 2 && k == 0) begin
        cfg_we = 1'b1; cfg_addr = CFG_AW'(cs * 16); cfg_wdata = newsetup;
        model_wr(cs, 0, newsetup);
      end
      mem_din = pat(k);
      #1;
      cs_on = on_b(k, cs_s, cs_p, ceff);
      st_on = on_b(k, st_s, st_p, ceff);
      e_ncs = 32'(6'h3F);
      if (cs < NUM_CS && cs_on) e_ncs[cs] = 1'b0;
      e_oe = wr && (k >= (wm ? st_s : cs_s));
      if (bwm) e_nbs = wr ? (~(be & lm & (st_on ? 15 : 0)) & 15) : 15;
      else     e_nbs = wr ? (~(be & lm) & 15) : (~lm & 15);
      chk("R2 ready low during access", 32'(req_ready), 32'd0);
      chk("R4 chip select", 32'(mem_ncs_n), e_ncs);
      chk("R3 read strobe", 32'(mem_nrd_n), 32'(!(!wr && st_on)));
      chk(bwm ? "R9 write strobe held" : "R8 write strobe", 32'(mem_nwe_n),
          32'(!(wr && st_on && !bwm)));
      chk(bwm ? "R9 lane strobes" : "R8 byte selects", 32'(mem_nbs_n), e_nbs);
      chk("R7 output enable", 32'(mem_oe), 32'(e_oe));
      chk("R5 address hold", 32'(mem_addr), 32'(addr));
      if (e_oe) chk("R7 write data", mem_dout, wd);
      if (cfgwhen != 0) chk("R11 old timing kept", 32'(mem_ncs_n), e_ncs);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk("R2 response pulse", 32'(resp_valid), 32'd1);
    chk("R2 ready after access", 32'(req_ready), 32'd1);
    if (!wr) chk(rm ? "R6 sample on read strobe" : "R6 sample on chip select",
                 resp_rdata, exp_rd);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_setup[i] = '0; m_pulse[i] = '0; m_cycle[i] = '0; m_mode[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R13 ready in reset", 32'(req_ready), 32'd1);
    chk("R13 strobes in reset", {mem_nbs_n, mem_nwe_n, mem_nrd_n, 26'(mem_ncs_n)},
        {4'hF, 1'b1, 1'b1, 26'(6'h3F)});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 oe and response after reset", {30'd0, mem_oe, resp_valid}, 32'd0);
    for (int i = 0; i < 24; i++) begin
      cfg_addr = CFG_AW'(i * 4);
      #1;
      chk("R13 registers cleared", cfg_rdata, 32'd0);
    end

    // R1 field widths and read-back
    for (int s = 0; s < 4; s++) cfg_wr(2, s, 32'hFFFF_FFFF);
    for (int s = 0; s < 4; s++) begin
      cfg_addr = CFG_AW'(32 + s * 4);
      #1;
      chk("R1 readback mask", cfg_rdata, wmask(s));
    end
    for (int s = 0; s < 4; s++) cfg_wr(2, s, 32'h0);
    // R12 banks beyond range and misaligned offsets ignored
    cfg_wr(6, 0, 32'hFFFF_FFFF);
    cfg_wr(7, 2, 32'hFFFF_FFFF);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = CFG_AW'(16 * 3 + 1); cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_addr = CFG_AW'(96); #1; chk("R12 bank 6 reads zero", cfg_rdata, 32'd0);
    cfg_addr = CFG_AW'(120); #1; chk("R12 bank 7 reads zero", cfg_rdata, 32'd0);
    cfg_addr = CFG_AW'(48); #1; chk("R12 misaligned write ignored", cfg_rdata, 32'd0);

    // R3 R4 R6 read sweep
    for (int a = 0; a < 3; a++) for (int b = 0; b < 3; b++)
      for (int d = 0; d < 3; d++) for (int e = 0; e < 3; e++)
        for (int ci = 0; ci < 3; ci++) for (int rm = 0; rm < 2; rm++) begin
          int cyc;
          cyc = (ci == 0) ? 0 : (ci == 1) ? 4 : 7;
          set_cs(1, (a << 24) | (d << 16) | 32'h0505, (b << 24) | (e << 16) | 32'h0303,
                 (cyc << 16) | 2, rm | (2 << 12));
          run_acc(1, 1'b0, 24'h0A0000 + 24'(a * 27 + b * 9 + d * 3 + e), 32'h0, 4'hF, 0, 0);
        end

    // R7 R8 R9 write sweep
    for (int a = 0; a < 3; a++) for (int bi = 0; bi < 2; bi++)
      for (int d = 0; d < 3; d++) for (int e = 0; e < 3; e++)
        for (int ci = 0; ci < 2; ci++) for (int wm = 0; wm < 2; wm++)
          for (int bw = 0; bw < 2; bw++) begin
            int cyc;
            cyc = (ci == 0) ? 3 : 6;
            set_cs(4, (a << 8) | d | 32'h0505_0000, ((bi * 3) << 8) | e | 32'h0303_0000,
                   cyc | (9 << 16), (wm << 1) | (bw << 8) | (2 << 12));
            run_acc(4, 1'b1, 24'h123400 + 24'(a * 3 + d), 32'hDEADBEEF ^ 32'(e * 77 + a),
                    4'b0110, 0, 0);
          end

    // R10 width codes
    for (int w = 0; w < 4; w++) for (int bw = 0; bw < 2; bw++) begin
      set_cs(0, 32'h0100_0201, 32'h0302_0201, 32'h0005_0005, (w << 12) | (bw << 8));
      run_acc(0, 1'b0, 24'h000040, 32'h0, 4'hF, 0, 0);
      run_acc(0, 1'b1, 24'h000044, 32'hCAFE_F00D, 4'b1011, 0, 0);
    end

    // R5 each chip select uses its own bank
    for (int cs = 0; cs < NUM_CS; cs++)
      set_cs(cs, cs << 24, (cs + 1) << 24, (cs + 3) << 16, 2 << 12);
    for (int cs = 0; cs < NUM_CS; cs++) run_acc(cs, 1'b0, 24'(cs * 256), 0, 4'hF, 0, 0);

    // R11 timings latched at acceptance
    set_cs(3, 32'h0000_0000, 32'h0200_0000, 32'h0006_0006, 2 << 12);
    run_acc(3, 1'b0, 24'h333333, 0, 4'hF, 1, 32'h0300_0000);
    run_acc(3, 1'b0, 24'h333334, 0, 4'hF, 0, 0);
    run_acc(3, 1'b0, 24'h333335, 0, 4'hF, 2, 32'h0100_0000);
    run_acc(3, 1'b0, 24'h333336, 0, 4'hF, 0, 0);

    // R12 out-of-range chip selects
    run_acc(6, 1'b0, 24'h666666, 0, 4'hF, 0, 0);
    run_acc(7, 1'b1, 24'h777777, 32'h1234_5678, 4'hF, 0, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule